// File: doc/BRIEF.md
# Mailbox Command Dispatcher

The dispatcher runs one host command per doorbell ring. The host writes a 32-bit command word with three fields: an 8-bit command code in bits 7:0, an 8-bit command set in bits 15:8, and a 16-bit payload length in bits 31:16. It then sets bit 0 of the control word. The block joins set and code into a 16-bit opcode, with the set as the upper byte. It searches a fixed table of supported commands for that opcode and compares the given length with the length that entry expects.

When the opcode is found and the length fits, one handler stub starts through a start/done handshake. Otherwise the command completes at once with an error code. On completion the block does three things in this order:
- It writes the return code into the status word.
- It rewrites the command word so that it holds only the resulting length.
- One cycle later, it drops the doorbell.

The host polls the doorbell, then reads the status and the length.

Top module: `mbox_dispatch`

## Requirements
- R1: After reset the doorbell is 0, the command word is 0 and the status word is 0.
- R2: The opcode is {set, code}. A supported opcode whose length matches completes with return code 0x00, and the length field holds the handler's output length. Opcode 0x0300 expects length 0 and gives 8. Opcode 0x0100 expects length 1 and gives 0x20.
- R3: An opcode missing from the table completes with return code 0x03, and the length field keeps the input length. Opcode 0x0001 is not in the table, while 0x0100 is.
- R4: A supported fixed-length opcode with a wrong length completes with return code 0x16. No handler runs, so the length field keeps the input length.
- R5: An entry whose expected length is 0xFFFF accepts any length. Opcode 0x0101 is such an entry; it echoes its input length as the output length.
- R6: On completion the status word holds the return code in bits 7:0, and bits 15:8 are zero.
- R7: On completion the set and code fields read zero. The command and status words are updated at least one cycle before the doorbell falls.
- R8: A return code reported by a handler is passed through. Opcode 0x4102 with length 8 gives 0x02 with output length 0.
- R9: While the doorbell is set, writes to the command word and to the control word are ignored.
- R10: An output length above PAYLOAD_BYTES is clamped to PAYLOAD_BYTES, and the return code becomes 0x04. Opcode 0x0401 with length 0x18 reports 0x200. An output equal to PAYLOAD_BYTES completes with 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 selects the command word, 1 selects the control word (bit 0 is the doorbell) |
| wr_data | input | 32 | Write data |
| cmd_reg_o | output | 32 | Command word: code [7:0], set [15:8], length [31:16] |
| status_o | output | 16 | Status word: return code in [7:0] |
| doorbell_o | output | 1 | Doorbell: 1 while a command is in progress |

## Verification
The bench builds the block with the default PAYLOAD_BYTES of 256. At that size an echo of 300 bytes and a fixed 0x200-byte report both overflow the buffer, while an echo of exactly 256 sits on the boundary. The clamp and the internal-error override are therefore reached from both the echo entry and a fixed-length entry. The table's mix of fixed lengths, one variable-length entry and one entry that returns an error drives every completion path at this setting. Handler latencies of one to four cycles leave enough busy time to land ignored writes in the middle of a command.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int LEN_W    = 16;
    localparam int NUM_CMDS = 6;
    localparam int IDX_W    = $clog2(NUM_CMDS);

    localparam logic [7:0] RC_OK          = 8'h00;
    localparam logic [7:0] RC_INVALID_IN  = 8'h02;
    localparam logic [7:0] RC_UNSUPPORTED = 8'h03;
    localparam logic [7:0] RC_INTERNAL    = 8'h04;
    localparam logic [7:0] RC_BAD_LENGTH  = 8'h16;

    localparam logic [LEN_W-1:0] LEN_ANY = '1;

    typedef struct packed {
        logic [15:0]      opcode;
        logic [LEN_W-1:0] in_len;
        logic [LEN_W-1:0] out_len;
        logic             echo;
        logic [7:0]       rc;
        logic [3:0]       lat;
    } cmd_ent_t;

    localparam cmd_ent_t CMD_TABLE [NUM_CMDS] = '{
        '{16'h0100, 16'd1,   16'h0020, 1'b0, 8'h00, 4'd2},
        '{16'h0101, LEN_ANY, 16'h0000, 1'b1, 8'h00, 4'd3},
        '{16'h0300, 16'd0,   16'h0008, 1'b0, 8'h00, 4'd1},
        '{16'h0301, 16'd8,   16'h0000, 1'b0, 8'h00, 4'd4},
        '{16'h4102, 16'd8,   16'h0000, 1'b0, 8'h02, 4'd2},
        '{16'h0401, 16'h18,  16'h0200, 1'b0, 8'h00, 4'd1}
    };

    typedef enum logic [2:0] {
        S_IDLE, S_DISPATCH, S_WAIT, S_FINISH, S_RELEASE
    } state_e;

endpackage

// File: rtl/mbox_lookup.sv
module mbox_lookup
    import mbox_pkg::*;
(
    input  logic [15:0]      opcode_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             len_ok_o
);
    logic [NUM_CMDS-1:0] match;

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_match
        assign match[g] = (CMD_TABLE[g].opcode == opcode_i);
    end

    always_comb begin
        hit_o    = 1'b0;
        idx_o    = '0;
        len_ok_o = 1'b0;
        for (int i = NUM_CMDS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o    = 1'b1;
                idx_o    = IDX_W'(i);
                len_ok_o = (CMD_TABLE[i].in_len == LEN_ANY) ||
                           (CMD_TABLE[i].in_len == len_i);
            end
        end
    end
endmodule

// File: rtl/mbox_handler_stub.sv
module mbox_handler_stub
    import mbox_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] in_len_i,
    output logic             done_o,
    output logic [LEN_W-1:0] out_len_o,
    output logic [7:0]       rc_o
);
    localparam cmd_ent_t ENT = CMD_TABLE[IDX];

    typedef struct packed {
        logic       busy;
        logic [3:0] cnt;
    } stub_t;

    stub_t s_d, s_q;

    assign done_o    = s_q.busy && (s_q.cnt == 4'd0);
    assign out_len_o = ENT.echo ? in_len_i : ENT.out_len;
    assign rc_o      = ENT.rc;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = ENT.lat - 4'd1;
        end else if (s_q.busy) begin
            if (s_q.cnt == 4'd0) s_d.busy = 1'b0;
            else                 s_d.cnt  = s_q.cnt - 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch
    import mbox_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_reg_o,
    output logic [15:0] status_o,
    output logic        doorbell_o
);
    localparam logic [LEN_W-1:0] PAYLOAD_LIM = LEN_W'(PAYLOAD_BYTES);

    typedef struct packed {
        state_e           state;
        logic             doorbell;
        logic [31:0]      cmd;
        logic [15:0]      status;
        logic [IDX_W-1:0] sel;
        logic [7:0]       rc;
        logic [LEN_W-1:0] len_res;
    } disp_t;

    disp_t st_d, st_q;

    logic             hit, len_ok;
    logic [IDX_W-1:0] idx;
    logic [NUM_CMDS-1:0] hstart, hdone;
    logic [LEN_W-1:0] hlen [NUM_CMDS];
    logic [7:0]       hrc  [NUM_CMDS];

    mbox_lookup u_lookup (
        .opcode_i (st_q.cmd[15:0]),
        .len_i    (st_q.cmd[31:16]),
        .hit_o    (hit),
        .idx_o    (idx),
        .len_ok_o (len_ok)
    );

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_handler
        assign hstart[g] = (st_q.state == S_DISPATCH) && hit && len_ok &&
                           (idx == IDX_W'(g));
        mbox_handler_stub #(.IDX(g)) u_stub (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (hstart[g]),
            .in_len_i  (st_q.cmd[31:16]),
            .done_o    (hdone[g]),
            .out_len_o (hlen[g]),
            .rc_o      (hrc[g])
        );
    end

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            S_IDLE: begin
                if (wr_en) begin
                    if (!wr_addr) begin
                        st_d.cmd = wr_data;
                    end else if (wr_data[0]) begin
                        st_d.doorbell = 1'b1;
                        st_d.state    = S_DISPATCH;
                    end
                end
            end
            S_DISPATCH: begin
                st_d.sel = idx;
                if (!hit) begin
                    st_d.rc      = RC_UNSUPPORTED;
                    st_d.len_res = st_q.cmd[31:16];
                    st_d.state   = S_FINISH;
                end else if (!len_ok) begin
                    st_d.rc      = RC_BAD_LENGTH;
                    st_d.len_res = st_q.cmd[31:16];
                    st_d.state   = S_FINISH;
                end else begin
                    st_d.state   = S_WAIT;
                end
            end
            S_WAIT: begin
                if (hdone[st_q.sel]) begin
                    if (hlen[st_q.sel] > PAYLOAD_LIM) begin
                        st_d.len_res = PAYLOAD_LIM;
                        st_d.rc      = RC_INTERNAL;
                    end else begin
                        st_d.len_res = hlen[st_q.sel];
                        st_d.rc      = hrc[st_q.sel];
                    end
                    st_d.state = S_FINISH;
                end
            end
            S_FINISH: begin
                st_d.cmd    = {st_q.len_res, 16'h0000};
                st_d.status = {8'h00, st_q.rc};
                st_d.state  = S_RELEASE;
            end
            S_RELEASE: begin
                st_d.doorbell = 1'b0;
                st_d.state    = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: S_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign cmd_reg_o  = st_q.cmd;
    assign status_o   = st_q.status;
    assign doorbell_o = st_q.doorbell;
endmodule

// File: rtl/mbox_dispatch_chk.sv
module mbox_dispatch_chk
    import mbox_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                doorbell,
    input logic [31:0]         cmd_reg,
    input logic [15:0]         status,
    input logic [NUM_CMDS-1:0] start_vec
);
    p_fields_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> (cmd_reg[15:0] == 16'h0000));

    p_regs_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> ($stable(cmd_reg) && $stable(status)));

    p_status_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> (status[15:8] == 8'h00));

    p_one_handler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_vec));

    p_start_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_vec) |-> doorbell);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(doorbell) && status[7:0] == 8'h00) |->
        (32'(cmd_reg[31:16]) <= 32'(PAYLOAD_BYTES)));
endmodule

bind mbox_dispatch mbox_dispatch_chk #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .doorbell  (doorbell_o),
    .cmd_reg   (cmd_reg_o),
    .status    (status_o),
    .start_vec (hstart)
);

// File: tb/tb_mbox_dispatch.sv
`timescale 1ns/1ps
module tb_mbox_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_reg_o;
    logic [15:0] status_o;
    logic        doorbell_o;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    mbox_dispatch #(.PAYLOAD_BYTES(256)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_reg_o(cmd_reg_o), .status_o(status_o),
        .doorbell_o(doorbell_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // waits for completion, checks R6/R7 shape, then result code and length
    task automatic finish_and_check(input string tag, input logic [7:0] exp_rc,
                                    input logic [15:0] exp_len);
        logic [31:0] prev;
        int n;
        prev = cmd_reg_o;
        n = 0;
        while (doorbell_o && n < 100) begin
            prev = cmd_reg_o;
            @(negedge clk);
            n++;
        end
        check(n < 100, {tag, " completion R7"}, 32'(n), 32'd100);
        check(prev == cmd_reg_o, {tag, " regs before doorbell drop R7"}, prev, cmd_reg_o);
        check(cmd_reg_o[15:0] == 16'h0, {tag, " set/code cleared R7"},
              32'(cmd_reg_o[15:0]), 32'h0);
        check(status_o[15:8] == 8'h0, {tag, " status upper R6"},
              32'(status_o), 32'(exp_rc));
        check(status_o[7:0] == exp_rc, {tag, " return code"},
              32'(status_o[7:0]), 32'(exp_rc));
        check(cmd_reg_o[31:16] == exp_len, {tag, " length"},
              32'(cmd_reg_o[31:16]), 32'(exp_len));
    endtask

    task automatic run_cmd(input string tag, input logic [7:0] set,
                           input logic [7:0] code, input logic [15:0] len,
                           input logic [7:0] exp_rc, input logic [15:0] exp_len);
        wr(1'b0, {len, set, code});
        wr(1'b1, 32'h1);
        finish_and_check(tag, exp_rc, exp_len);
    endtask

    task automatic t_reset;
        check(doorbell_o == 1'b0, "R1 doorbell", 32'(doorbell_o), 32'h0);
        check(cmd_reg_o == 32'h0, "R1 command", cmd_reg_o, 32'h0);
        check(status_o == 16'h0, "R1 status", 32'(status_o), 32'h0);
    endtask

    task automatic t_supported;
        run_cmd("R2 op0300", 8'h03, 8'h00, 16'd0, 8'h00, 16'd8);
        run_cmd("R2 op0100", 8'h01, 8'h00, 16'd1, 8'h00, 16'h20);
    endtask

    task automatic t_unsupported;
        run_cmd("R3 op0250", 8'h02, 8'h50, 16'd3, 8'h03, 16'd3);
        run_cmd("R3 byte order op0001", 8'h00, 8'h01, 16'd1, 8'h03, 16'd1);
    endtask

    task automatic t_bad_length;
        run_cmd("R4 op0100 len2", 8'h01, 8'h00, 16'd2, 8'h16, 16'd2);
        run_cmd("R4 op0301 len7", 8'h03, 8'h01, 16'd7, 8'h16, 16'd7);
        run_cmd("R4 op0300 len1", 8'h03, 8'h00, 16'd1, 8'h16, 16'd1);
    endtask

    task automatic t_variable;
        run_cmd("R5 echo 0x40", 8'h01, 8'h01, 16'h40, 8'h00, 16'h40);
        run_cmd("R5 echo 0", 8'h01, 8'h01, 16'd0, 8'h00, 16'd0);
    endtask

    task automatic t_handler_rc;
        run_cmd("R8 op4102", 8'h41, 8'h02, 16'd8, 8'h02, 16'd0);
    endtask

    task automatic t_clamp;
        run_cmd("R10 op0401", 8'h04, 8'h01, 16'h18, 8'h04, 16'd256);
        run_cmd("R10 echo 300", 8'h01, 8'h01, 16'd300, 8'h04, 16'd256);
        run_cmd("R10 echo 256 boundary", 8'h01, 8'h01, 16'd256, 8'h00, 16'd256);
    endtask

    task automatic t_busy_ignore;
        wr(1'b0, {16'd5, 8'h01, 8'h01});
        wr(1'b1, 32'h1);
        check(doorbell_o == 1'b1, "R9 doorbell set", 32'(doorbell_o), 32'h1);
        wr(1'b0, {16'd0, 8'h03, 8'h00});
        wr(1'b1, 32'h0);
        check(doorbell_o == 1'b1, "R9 clear ignored", 32'(doorbell_o), 32'h1);
        wr(1'b1, 32'h1);
        finish_and_check("R9 busy writes", 8'h00, 16'd5);
        repeat (10) @(negedge clk);
        check(doorbell_o == 1'b0, "R9 no rerun", 32'(doorbell_o), 32'h0);
        check(cmd_reg_o == {16'd5, 16'h0}, "R9 cmd kept", cmd_reg_o, {16'd5, 16'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_supported();
        t_unsupported();
        t_bad_length();
        t_variable();
        t_handler_rc();
        t_clamp();
        t_busy_ignore();
        if (!done_run) begin
            done_run = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            done_run = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule